// File: doc/BRIEF.md
# MDIO Management Frame Controller with Status Polling

This block is the master side of a two-wire management bus (MDC clock, MDIO data) serving two transceivers. The transceivers share the clock and the outgoing data, but each has its own MDIO line. A select pin picks which line is driven and which line is listened to. Software issues a 32-bit management frame through a valid/ready port. The block sends a 32-bit all-ones preamble and then the frame, most significant bit first. On a read it releases the line through the turnaround and captures 16 data bits. Completion shows up in bit 16 of the frame status word.

When polling is enabled and bit-bang is off, the block issues read frames back to back to one configured transceiver register whenever no software frame is waiting. The last value read is kept in the upper half of a 32-bit basic/status word. Every bit that differs from the previous value is latched in the lower half. Any latched bit whose mask bit is 0 raises the interrupt, and a read strobe on the status word clears the latched bits. A bit-bang mode hands MDC, MDIO out and the output enable to three plain input pins.

The frame port follows valid/ready rules. A frame is taken on a clock edge where `frm_valid` and `frm_ready` are both high. `frm_ready` is high only while no frame or poll is on the wire and bit-bang is off. While `frm_valid` is high and the frame has not yet been taken, `frm_data` must stay constant. MDC runs at the system clock divided by 2·HALF_DIV.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, `frm_status` is 0x00010000, `bs_value` is 0, `irq` is 0, `mdc` is low and both line enables are low.
- R2: A frame is accepted only when `frm_ready` is high. `frm_ready` is low from the edge that accepts a frame or starts a poll until that transfer ends.
- R3: Each transfer sends 32 one-bits and then the 32 frame bits, MSB first. Each bit lasts 2·HALF_DIV clocks, with MDC low for the first half and high for the second. MDIO changes only while MDC is low.
- R4: For opcode 10 in frame bits 29:28 (a read), the master releases the line from stream bit 46 (frame bit 17) to the end. It samples the selected line at each rising MDC edge of the last 16 bits, MSB first.
- R5: At the end of a software frame, `frm_status` bit 16 becomes 1. For a read, bits 15:0 are replaced by the captured data. For a write, the word is otherwise unchanged.
- R6: On acceptance, `frm_status` takes the written word with bit 16 forced to 0.
- R7: With `cfg_line_sel` at 0, only `mdio_oe[0]` may be high and input comes from `mdio_i[0]`. With `cfg_line_sel` at 1, line 1 is used instead. `bb_din` shows the selected input.
- R8: With `cfg_poll_en` high and `cfg_bb_en` low, each idle cycle with no frame pending starts a read frame of start 01, opcode 10, PHY `cfg_poll_phy`, register `cfg_poll_reg`, turnaround 10 and data 0.
- R9: At the end of each poll, `bs_value[31:16]` takes the value read and `bs_value[15:0]` ORs in the XOR of the old and new values.
- R10: `irq` is high exactly when some bit of `bs_value[15:0]` is 1 and the matching `irq_mask` bit is 0.
- R11: `bs_rd` clears the changed-bit half on the next edge. A change latched by a poll ending on that same edge is kept.
- R12: In an idle cycle with both a pending frame and polling enabled, the frame is taken and no poll starts.
- R13: With `cfg_bb_en` high, `mdc`, `mdio_o` and the selected enable follow `bb_mdc`, `bb_dout` and `bb_oe`. No frame is accepted and no poll starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_line_sel | input | 1 | Selects transceiver line 0 or 1 |
| cfg_poll_en | input | 1 | Enables status polling |
| cfg_bb_en | input | 1 | Enables bit-bang mode |
| cfg_poll_reg | input | 5 | Register address used by polls |
| cfg_poll_phy | input | 5 | PHY address used by polls |
| frm_valid | input | 1 | Frame request valid |
| frm_ready | output | 1 | Frame request accepted when high with valid |
| frm_data | input | 32 | Frame word: start, opcode, PHY, register, turnaround, data |
| frm_status | output | 32 | Last frame word; bit 16 set on completion, read data in 15:0 |
| bb_mdc | input | 1 | Bit-bang clock value |
| bb_dout | input | 1 | Bit-bang data value |
| bb_oe | input | 1 | Bit-bang output enable |
| bb_din | output | 1 | Selected MDIO input |
| irq_mask | input | 16 | 1 masks the matching changed bit |
| bs_rd | input | 1 | Read strobe that clears the changed bits |
| bs_value | output | 32 | Last polled value (31:16) and changed bits (15:0) |
| irq | output | 1 | Unmasked status change |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 2 | Per-line output enable |
| mdio_i | input | 2 | Per-line data in |

## Verification
Two pairs of functions can meet in a single cycle. The first pair is a status read strobe and the end of a poll. The bench waits for the last clock of a poll and raises `bs_rd` in exactly that cycle. It then expects the old changed bits to vanish while the new XOR bits survive. The second pair is a waiting frame and the start of a poll. The bench raises `frm_valid` in the idle cycle that follows a poll, with polling still enabled. It then judges from the frame status and the bit stream on MDIO that the frame went out and no poll did.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRM_W = 32;
  localparam int DAT_W = 16;
  localparam int TA_LSB = 16;
  localparam logic [1:0] START_SEQ = 2'b01;
  localparam logic [1:0] OP_READ   = 2'b10;
  localparam logic [1:0] TA_IDLE   = 2'b10;

  function automatic logic [FRM_W-1:0] poll_frame(input logic [4:0] phy_a, input logic [4:0] reg_a);
    return {START_SEQ, OP_READ, phy_a, reg_a, TA_IDLE, {DAT_W{1'b0}}};
  endfunction
endpackage

// File: rtl/mdio_shift_engine.sv
module mdio_shift_engine
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int PRE_LEN  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [FRM_W-1:0] word,
  input  logic             sdi,
  output logic             busy,
  output logic             done,
  output logic             mdc,
  output logic             sdo,
  output logic             drive,
  output logic             is_read,
  output logic [DAT_W-1:0] rdata
);
  localparam int PERIOD  = 2 * HALF_DIV;
  localparam int TOT     = PRE_LEN + FRM_W;
  localparam int PW      = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam int BW      = $clog2(TOT);
  localparam int DAT_POS = TOT - DAT_W;
  localparam int TA_POS  = DAT_POS - 2;

  logic [PW-1:0]    ph;
  logic [BW-1:0]    bi;
  logic [TOT-1:0]   sh;
  logic             busy_q, rd_q;
  logic [DAT_W-1:0] cap;

  wire last_ph = (ph == PW'(PERIOD - 1));
  wire mid_ph  = (ph == PW'(HALF_DIV));
  wire last_bi = (bi == BW'(TOT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      ph     <= '0;
      bi     <= '0;
      sh     <= '1;
      cap    <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        ph     <= '0;
        bi     <= '0;
        sh     <= {{PRE_LEN{1'b1}}, word};
        rd_q   <= (word[FRM_W-3:FRM_W-4] == OP_READ);
      end
    end else begin
      if (mid_ph && rd_q && (bi >= BW'(DAT_POS)))
        cap <= {cap[DAT_W-2:0], sdi};
      if (last_ph) begin
        ph <= '0;
        if (last_bi) begin
          busy_q <= 1'b0;
        end else begin
          bi <= bi + 1'b1;
          sh <= {sh[TOT-2:0], 1'b1};
        end
      end else begin
        ph <= ph + 1'b1;
      end
    end
  end

  assign busy    = busy_q;
  assign done    = busy_q && last_ph && last_bi;
  assign mdc     = busy_q && !(ph < PW'(HALF_DIV));
  assign sdo     = busy_q ? sh[TOT-1] : 1'b1;
  assign drive   = busy_q && !(rd_q && (bi >= BW'(TA_POS)));
  assign is_read = rd_q;
  assign rdata   = cap;
endmodule

// File: rtl/mdio_poll_status.sv
module mdio_poll_status #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd,
  input  logic [DW-1:0] newv,
  input  logic          clr,
  input  logic [DW-1:0] mask,
  output logic [2*DW-1:0] bs,
  output logic          irq
);
  logic [DW-1:0] basic, chg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      basic <= '0;
      chg   <= '0;
    end else begin
      if (upd) basic <= newv;
      chg <= (clr ? '0 : chg) | (upd ? (basic ^ newv) : '0);
    end
  end

  assign bs  = {basic, chg};
  assign irq = |(chg & ~mask);
endmodule

// File: rtl/mdio_pin_mux.sv
module mdio_pin_mux #(
  parameter int NUM_LINES = 2
) (
  input  logic                         bb_en,
  input  logic                         bb_mdc,
  input  logic                         bb_dout,
  input  logic                         bb_oe,
  input  logic                         eng_mdc,
  input  logic                         eng_sdo,
  input  logic                         eng_drive,
  input  logic [$clog2(NUM_LINES)-1:0] sel,
  input  logic [NUM_LINES-1:0]         line_in,
  output logic                         mdc,
  output logic                         mdio_o,
  output logic [NUM_LINES-1:0]         mdio_oe,
  output logic                         sdi
);
  localparam int SW = $clog2(NUM_LINES);
  logic oe_any;

  assign mdc    = bb_en ? bb_mdc  : eng_mdc;
  assign mdio_o = bb_en ? bb_dout : eng_sdo;
  assign oe_any = bb_en ? bb_oe   : eng_drive;
  assign sdi    = line_in[sel];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    assign mdio_oe[g] = oe_any && (sel == SW'(g));
  end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int PRE_LEN  = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_line_sel,
  input  logic        cfg_poll_en,
  input  logic        cfg_bb_en,
  input  logic [4:0]  cfg_poll_reg,
  input  logic [4:0]  cfg_poll_phy,
  input  logic        frm_valid,
  output logic        frm_ready,
  input  logic [31:0] frm_data,
  output logic [31:0] frm_status,
  input  logic        bb_mdc,
  input  logic        bb_dout,
  input  logic        bb_oe,
  output logic        bb_din,
  input  logic [15:0] irq_mask,
  input  logic        bs_rd,
  output logic [31:0] bs_value,
  output logic        irq,
  output logic        mdc,
  output logic        mdio_o,
  output logic [1:0]  mdio_oe,
  input  logic [1:0]  mdio_i
);
  localparam int NUM_LINES = 2;

  logic             eng_busy, eng_done, eng_mdc, eng_sdo, eng_drive, eng_rd, sdi;
  logic [DAT_W-1:0] eng_rdata;
  logic             frm_fire, poll_go, eng_start, cur_poll, poll_upd;
  logic [FRM_W-1:0] eng_word, frm_reg;

  assign frm_ready = !eng_busy && !cfg_bb_en;
  assign frm_fire  = frm_valid && frm_ready;
  assign poll_go   = !eng_busy && !cfg_bb_en && cfg_poll_en && !frm_valid;
  assign eng_start = frm_fire || poll_go;
  assign eng_word  = frm_fire ? frm_data : poll_frame(cfg_poll_phy, cfg_poll_reg);
  assign poll_upd  = eng_done && cur_poll;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frm_reg  <= FRM_W'(1) << TA_LSB;
      cur_poll <= 1'b0;
    end else begin
      if (frm_fire) begin
        frm_reg         <= frm_data;
        frm_reg[TA_LSB] <= 1'b0;
        cur_poll        <= 1'b0;
      end else if (poll_go) begin
        cur_poll <= 1'b1;
      end
      if (eng_done && !cur_poll) begin
        frm_reg[TA_LSB] <= 1'b1;
        if (eng_rd) frm_reg[DAT_W-1:0] <= eng_rdata;
      end
    end
  end

  mdio_shift_engine #(.HALF_DIV(HALF_DIV), .PRE_LEN(PRE_LEN)) eng_i (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .word(eng_word), .sdi(sdi),
    .busy(eng_busy), .done(eng_done), .mdc(eng_mdc), .sdo(eng_sdo),
    .drive(eng_drive), .is_read(eng_rd), .rdata(eng_rdata)
  );

  mdio_poll_status #(.DW(DAT_W)) stat_i (
    .clk(clk), .rst_n(rst_n), .upd(poll_upd), .newv(eng_rdata), .clr(bs_rd),
    .mask(irq_mask), .bs(bs_value), .irq(irq)
  );

  mdio_pin_mux #(.NUM_LINES(NUM_LINES)) mux_i (
    .bb_en(cfg_bb_en), .bb_mdc(bb_mdc), .bb_dout(bb_dout), .bb_oe(bb_oe),
    .eng_mdc(eng_mdc), .eng_sdo(eng_sdo), .eng_drive(eng_drive),
    .sel(cfg_line_sel), .line_in(mdio_i), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .sdi(sdi)
  );

  assign frm_status = frm_reg;
  assign bb_din     = sdi;
endmodule

// File: rtl/mdio_mgmt_master_chk.sv
module mdio_mgmt_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_bb_en,
  input logic        frm_valid,
  input logic        frm_ready,
  input logic [31:0] frm_data,
  input logic [31:0] frm_status,
  input logic        bs_rd,
  input logic [31:0] bs_value,
  input logic        mdc,
  input logic        mdio_o,
  input logic [1:0]  mdio_oe,
  input logic        eng_busy,
  input logic        cur_poll,
  input logic        poll_upd
);
  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_ready) |=> !frm_ready);

  assert_accept_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_ready) |=> (!frm_status[16] &&
      frm_status[31:17] == $past(frm_data[31:17]) &&
      frm_status[15:0] == $past(frm_data[15:0])));

  assert_done_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(eng_busy) && !cur_poll) |-> frm_status[16]);

  assert_data_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_bb_en && $past(!cfg_bb_en) && $rose(mdc)) |-> $stable(mdio_o));

  assert_one_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mdio_oe));

  assert_read_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bs_rd && !poll_upd) |=> (bs_value[15:0] == 16'h0));
endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_bb_en(cfg_bb_en), .frm_valid(frm_valid),
  .frm_ready(frm_ready), .frm_data(frm_data), .frm_status(frm_status),
  .bs_rd(bs_rd), .bs_value(bs_value), .mdc(mdc), .mdio_o(mdio_o),
  .mdio_oe(mdio_oe), .eng_busy(eng_busy), .cur_poll(cur_poll), .poll_upd(poll_upd)
);

// File: tb/mdio_mgmt_master_tb_top.sv
module mdio_mgmt_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 2;
  localparam int P    = 2 * HALF;
  localparam int TOT  = 64;
  localparam int LAST = TOT * P - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_sel = 0, cfg_poll = 0, cfg_bb = 0;
  logic [4:0] cfg_preg = 0, cfg_pphy = 0;
  logic frm_valid = 0, frm_ready;
  logic [31:0] frm_data = 0, frm_status;
  logic bb_mdc = 0, bb_dout = 0, bb_oe = 0, bb_din;
  logic [15:0] irq_mask = 16'hFFFF;
  logic bs_rd = 0;
  logic [31:0] bs_value;
  logic irq, mdc, mdio_o;
  logic [1:0] mdio_oe;
  logic [1:0] mdio_i = 2'b11;

  mdio_mgmt_master #(.HALF_DIV(HALF), .PRE_LEN(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_line_sel(cfg_sel), .cfg_poll_en(cfg_poll),
    .cfg_bb_en(cfg_bb), .cfg_poll_reg(cfg_preg), .cfg_poll_phy(cfg_pphy),
    .frm_valid(frm_valid), .frm_ready(frm_ready), .frm_data(frm_data),
    .frm_status(frm_status), .bb_mdc(bb_mdc), .bb_dout(bb_dout), .bb_oe(bb_oe),
    .bb_din(bb_din), .irq_mask(irq_mask), .bs_rd(bs_rd), .bs_value(bs_value),
    .irq(irq), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit model_on = 0, ended = 0;
  bit m_busy = 0, m_poll = 0, m_rd = 0;
  int m_t = 0;
  logic [63:0] m_stream = '1;
  logic [15:0] m_rdat = 0, m_basic = 0, m_chg = 0;
  logic [31:0] m_frm = 32'h0001_0000;
  logic [15:0] phy_val [2];

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Behavioural reference: time-slot counter since start of a transfer
  int slot;
  bit in_data, e_mdc, e_mo, e_any, done, sdi_v;
  logic [15:0] nchg;
  string rq;
  always @(negedge clk) begin
    if (rst_n && model_on) begin
      slot = m_t / P;
      in_data = m_busy && m_rd && slot >= TOT - 16;
      for (int i = 0; i < 2; i++)
        mdio_i[i] = in_data ? ((i == int'(cfg_sel)) ? phy_val[i][15 - (slot - (TOT - 16))] : 1'b0) : 1'b1;
      #1;
      e_mdc = cfg_bb ? bb_mdc  : (m_busy && (m_t % P) >= HALF);
      e_mo  = cfg_bb ? bb_dout : (m_busy ? m_stream[63 - slot] : 1'b1);
      e_any = cfg_bb ? bb_oe   : (m_busy && !(m_rd && slot >= TOT - 18));
      rq = cfg_bb ? "R13" : ((m_busy && m_poll) ? "R8" : "R3");
      chk(rq, "mdc", 32'(mdc), 32'(e_mdc));
      chk(rq, "mdio_o", 32'(mdio_o), 32'(e_mo));
      chk("R7", "mdio_oe", 32'(mdio_oe), {30'd0, e_any && cfg_sel, e_any && !cfg_sel});
      chk("R7", "bb_din", 32'(bb_din), 32'(mdio_i[cfg_sel]));
      chk("R2", "frm_ready", 32'(frm_ready), 32'(!m_busy && !cfg_bb));
      chk("R5", "frm_status", frm_status, m_frm);
      chk("R9", "bs_value", bs_value, {m_basic, m_chg});
      chk("R10", "irq", 32'(irq), 32'(|(m_chg & ~irq_mask)));
      // advance one clock
      sdi_v = mdio_i[cfg_sel];
      done = m_busy && m_t == LAST;
      if (m_busy && (m_t % P) == HALF && m_rd && slot >= TOT - 16)
        m_rdat = {m_rdat[14:0], sdi_v};
      nchg = bs_rd ? 16'h0 : m_chg;
      if (done) begin
        if (m_poll) begin
          nchg = nchg | (m_basic ^ m_rdat);
          m_basic = m_rdat;
        end else begin
          m_frm[16] = 1'b1;
          if (m_rd) m_frm[15:0] = m_rdat;
        end
      end
      m_chg = nchg;
      if (m_busy) begin
        if (done) m_busy = 0; else m_t++;
      end else if (!cfg_bb && frm_valid) begin
        m_busy = 1; m_poll = 0; m_t = 0;
        m_frm = frm_data; m_frm[16] = 1'b0;
        m_stream = {32'hFFFF_FFFF, frm_data};
        m_rd = frm_data[29:28] == 2'b10;
      end else if (!cfg_bb && cfg_poll) begin
        m_busy = 1; m_poll = 1; m_t = 0; m_rd = 1;
        m_stream = {32'hFFFF_FFFF, 2'b01, 2'b10, cfg_pphy, cfg_preg, 2'b10, 16'h0};
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic send_frame(input logic [31:0] w);
    bit acc = 0;
    frm_data = w; frm_valid = 1;
    while (!acc) begin
      @(negedge clk); #2; acc = frm_ready;
      tick();
    end
    frm_valid = 0;
  endtask

  task automatic wait_idle();
    do tick(); while (m_busy);
  endtask

  task automatic wait_poll_done();
    do tick(); while (!(m_busy && m_poll && m_t == LAST));
    tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      n_chk++; n_fail++;
      $display("FAIL R2 watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  logic [31:0] w, prev;
  initial begin
    phy_val[0] = 16'h0; phy_val[1] = 16'h0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    chk("R1", "frm_status", frm_status, 32'h0001_0000);
    chk("R1", "bs_value", bs_value, 32'h0);
    chk("R1", "irq", 32'(irq), 32'h0);
    chk("R1", "mdc", 32'(mdc), 32'h0);
    chk("R1", "mdio_oe", 32'(mdio_oe), 32'h0);
    model_on = 1;

    // write on line 0
    w = 32'h5002_0000 | (32'd3 << 23) | (32'd4 << 18) | 32'h0000_A5C3;
    send_frame(w);
    chk("R6", "status after accept", frm_status, w & ~32'h0001_0000);
    wait_idle();
    chk("R5", "write done", frm_status, w | 32'h0001_0000);

    // read on line 0
    phy_val[0] = 16'h1234;
    w = 32'h6002_0000 | (32'd3 << 23) | (32'd2 << 18);
    send_frame(w);
    wait_idle();
    chk("R4", "read data line0", frm_status, {w[31:17], 1'b1, 16'h1234});

    // read on line 1
    cfg_sel = 1; phy_val[1] = 16'hBEEF;
    tick();
    send_frame(32'h6002_0000 | (32'd1 << 18));
    wait_idle();
    chk("R7", "read data line1", frm_status[15:0], 32'h0000_BEEF);
    cfg_sel = 0;
    tick();

    // bit-bang
    prev = frm_status;
    cfg_bb = 1; frm_valid = 1; frm_data = 32'h5002_0000;
    for (int k = 0; k < 8; k++) begin
      tick();
      bb_mdc = k[0]; bb_dout = k[1]; bb_oe = k[2];
      #1;
      chk("R13", "bb mdc", 32'(mdc), 32'(k[0]));
      chk("R13", "bb mdio_o", 32'(mdio_o), 32'(k[1]));
      chk("R13", "bb oe", 32'(mdio_oe), {31'd0, k[2]});
      chk("R13", "bb ready", 32'(frm_ready), 32'h0);
    end
    frm_valid = 0;
    tick();
    cfg_bb = 0; bb_oe = 0;
    tick();
    chk("R13", "status untouched", frm_status, prev);

    // polling
    cfg_pphy = 5'd1; cfg_preg = 5'd5; irq_mask = 16'h000F; phy_val[0] = 16'h00F0;
    cfg_poll = 1;
    wait_poll_done();
    chk("R9", "first poll", bs_value, 32'h00F0_00F0);
    chk("R10", "irq unmasked", 32'(irq), 32'h1);
    irq_mask = 16'hFFFF; #1;
    chk("R10", "irq all masked", 32'(irq), 32'h0);
    irq_mask = 16'h000F;
    phy_val[0] = 16'h00FF;
    bs_rd = 1; tick(); bs_rd = 0;
    chk("R11", "clear", bs_value[15:0], 32'h0);
    wait_poll_done();
    chk("R9", "second poll", bs_value, 32'h00FF_000F);
    chk("R10", "masked change", 32'(irq), 32'h0);
    phy_val[0] = 16'h0F0F;
    do tick(); while (!(m_busy && m_poll && m_t == LAST));
    bs_rd = 1; tick(); bs_rd = 0;
    chk("R11", "clear with same-cycle change", bs_value, 32'h0F0F_0FF0);
    chk("R10", "irq after merge", 32'(irq), 32'h1);

    // frame against poll in the idle cycle
    w = 32'h6002_0000 | (32'd2 << 23) | (32'd1 << 18);
    send_frame(w);
    chk("R12", "frame won over poll", frm_status, w);
    cfg_poll = 0;
    wait_idle();
    chk("R4", "read after poll", frm_status, {w[31:17], 1'b1, 16'h0F0F});
    repeat (4) tick();

    ended = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule